// File: doc/BRIEF.md
# Interrupt Status and Enable Register Bank

This block holds the interrupt state of a serial controller that has a transmit FIFO and a receive FIFO. The FIFO logic feeds it two kinds of inputs. Overflow and underflow arrive as one-cycle event pulses, and the block latches them. The other four conditions arrive as live levels, which the block shows as they are.

Software reads a status word and clears latched events by writing ones back to it. The enable mask has no plain read-write register. Software sets mask bits by writing ones to one port and clears mask bits by writing ones to another. A separate read-only port shows the current mask. The interrupt line is high while any status bit is set together with its mask bit.

The register bus is a simple single-cycle interface. A write is taken on the clock edge when `bus_wr` is high. Read data depends combinationally on `bus_addr`, and reading has no side effects.

Top module: `irq_bank`

## Requirements
- R1: After reset is released, with all level inputs low, the status word and the mask view both read 0 and `irq` is low.
- R2: Status bit positions are shared by every port:
  - bit 0: receive overflow (latched)
  - bit 2: transmit below threshold (level)
  - bit 3: transmit full (level)
  - bit 4: receive not empty (level)
  - bit 5: receive full (level)
  - bit 6: transmit underflow (latched)

  The status word is read at offset 0x04. Each level bit equals its input in the same cycle.
- R3: A latched bit (0 or 6) is set on the clock edge after its event pulse. It stays set until a status write with a one in that bit.
- R4: A status write clears only the latched bits written as one. Zeros leave the status unchanged. Ones written to level bits have no effect while their condition persists.
- R5: When an event pulse and a status write that clears the same bit fall on the same edge, the bit ends up set.
- R6: A write to offset 0x08 sets the mask bits written as one and leaves all other mask bits unchanged.
- R7: A write to offset 0x0C clears the mask bits written as one and leaves all other mask bits unchanged.
- R8: Offset 0x10 reads the current mask. Offsets 0x08 and 0x0C read as 0.
- R9: Reserved bits (bit 1 and bits 7 and up) always read as 0, and writing them has no effect. For example, writing all ones to 0x08 gives a mask view of 0x7D.
- R10: `irq` is high, in the same cycle, exactly when some status bit and its mask bit are both 1.
- R11: Writes to any offset other than 0x04, 0x08 and 0x0C change neither the mask nor the status. This includes a write to the read-only mask view at 0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, taken on the rising edge |
| bus_addr | input | ADDR_W | Byte offset for reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| ev_rx_ovf | input | 1 | Receive overflow event pulse |
| ev_tx_unf | input | 1 | Transmit underflow event pulse |
| lv_tx_low | input | 1 | Transmit FIFO below threshold (level) |
| lv_tx_full | input | 1 | Transmit FIFO full (level) |
| lv_rx_nempty | input | 1 | Receive FIFO not empty (level) |
| lv_rx_full | input | 1 | Receive FIFO full (level) |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets several corner cases:
- **Event arriving on the clearing edge.** A design that lets the clear win would silently lose an overflow.
- **Clearing a level bit while its condition holds.** A design that latched level bits would show a stale flag after the FIFO condition went away.
- **Zero bits in set and clear writes.** A design that wrote the mask directly instead of setting or clearing would drop bits that were enabled earlier.
- **Reserved bits.** A design that stored reserved bits would read back 0xFF instead of 0x7D.
- **Write to the read-only view.** A design that decoded the view as writable would change the mask on that write.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int IRQ_W = 7;

  localparam int B_RX_OVF  = 0;
  localparam int B_TX_LOW  = 2;
  localparam int B_TX_FULL = 3;
  localparam int B_RX_NE   = 4;
  localparam int B_RX_FULL = 5;
  localparam int B_TX_UNF  = 6;

  localparam logic [IRQ_W-1:0] STICKY_BITS = (7'(1) << B_RX_OVF) | (7'(1) << B_TX_UNF);
  localparam logic [IRQ_W-1:0] LEVEL_BITS  = (7'(1) << B_TX_LOW) | (7'(1) << B_TX_FULL)
                                           | (7'(1) << B_RX_NE)  | (7'(1) << B_RX_FULL);
  localparam logic [IRQ_W-1:0] LIVE_BITS   = STICKY_BITS | LEVEL_BITS;

  typedef enum logic [1:0] {RD_ZERO, RD_STAT, RD_MASK} rd_sel_e;

  // Keep only implemented bit positions of a bus word.
  function automatic logic [IRQ_W-1:0] f_live(input logic [IRQ_W-1:0] w);
    return w & LIVE_BITS;
  endfunction

  // Pending interrupt reduction.
  function automatic logic f_pending(input logic [IRQ_W-1:0] st, input logic [IRQ_W-1:0] mk);
    return |(st & mk);
  endfunction

  // Next value of one latched bit: a new event wins over a clear.
  function automatic logic f_sticky_next(input logic cur, input logic ev, input logic clr);
    return ev | (cur & ~clr);
  endfunction
endpackage

// File: rtl/irq_bank_decode.sv
module irq_bank_decode #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFS_STAT = 'h04,
  parameter logic [ADDR_W-1:0] OFS_SET  = 'h08,
  parameter logic [ADDR_W-1:0] OFS_CLR  = 'h0C,
  parameter logic [ADDR_W-1:0] OFS_VIEW = 'h10
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              wr_stat,
  output logic              wr_set,
  output logic              wr_clr,
  output irq_bank_pkg::rd_sel_e rd_sel
);
  import irq_bank_pkg::*;

  assign wr_stat = bus_wr && (bus_addr == OFS_STAT);
  assign wr_set  = bus_wr && (bus_addr == OFS_SET);
  assign wr_clr  = bus_wr && (bus_addr == OFS_CLR);

  always_comb begin
    if (bus_addr == OFS_STAT)      rd_sel = RD_STAT;
    else if (bus_addr == OFS_VIEW) rd_sel = RD_MASK;
    else                           rd_sel = RD_ZERO;
  end
endmodule

// File: rtl/irq_bank_status.sv
module irq_bank_status (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_stat,
  input  logic [irq_bank_pkg::IRQ_W-1:0] wr_bits,
  input  logic [irq_bank_pkg::IRQ_W-1:0] ev_vec,
  input  logic [irq_bank_pkg::IRQ_W-1:0] lv_vec,
  output logic [irq_bank_pkg::IRQ_W-1:0] stat
);
  import irq_bank_pkg::*;

  for (genvar i = 0; i < IRQ_W; i++) begin : g_bit
    if (STICKY_BITS[i]) begin : g_sticky
      logic q;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= f_sticky_next(q, ev_vec[i], wr_stat && wr_bits[i]);
      end
      assign stat[i] = q;
    end else if (LEVEL_BITS[i]) begin : g_level
      assign stat[i] = lv_vec[i];
    end else begin : g_rsvd
      assign stat[i] = 1'b0;
    end
  end

  logic unused_inputs;
  assign unused_inputs = ^{ev_vec & ~STICKY_BITS, lv_vec & ~LEVEL_BITS};
endmodule

// File: rtl/irq_bank_mask.sv
module irq_bank_mask (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_set,
  input  logic wr_clr,
  input  logic [irq_bank_pkg::IRQ_W-1:0] wr_bits,
  output logic [irq_bank_pkg::IRQ_W-1:0] mask
);
  import irq_bank_pkg::*;

  for (genvar i = 0; i < IRQ_W; i++) begin : g_bit
    if (LIVE_BITS[i]) begin : g_impl
      logic q;
      always_ff @(posedge clk) begin
        if (!rst_n)                     q <= 1'b0;
        else if (wr_set && wr_bits[i])  q <= 1'b1;
        else if (wr_clr && wr_bits[i])  q <= 1'b0;
      end
      assign mask[i] = q;
    end else begin : g_rsvd
      assign mask[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFS_STAT = 'h04,
  parameter logic [ADDR_W-1:0] OFS_SET  = 'h08,
  parameter logic [ADDR_W-1:0] OFS_CLR  = 'h0C,
  parameter logic [ADDR_W-1:0] OFS_VIEW = 'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ev_rx_ovf,
  input  logic              ev_tx_unf,
  input  logic              lv_tx_low,
  input  logic              lv_tx_full,
  input  logic              lv_rx_nempty,
  input  logic              lv_rx_full,
  output logic              irq
);
  import irq_bank_pkg::*;

  localparam int PAD_W = DATA_W - IRQ_W;

  logic              wr_stat, wr_set, wr_clr;
  rd_sel_e           rd_sel;
  logic [IRQ_W-1:0]  wr_bits, ev_vec, lv_vec, stat_q, mask_q;

  assign wr_bits = f_live(bus_wdata[IRQ_W-1:0]);

  always_comb begin
    ev_vec = '0;
    ev_vec[B_RX_OVF] = ev_rx_ovf;
    ev_vec[B_TX_UNF] = ev_tx_unf;
    lv_vec = '0;
    lv_vec[B_TX_LOW]  = lv_tx_low;
    lv_vec[B_TX_FULL] = lv_tx_full;
    lv_vec[B_RX_NE]   = lv_rx_nempty;
    lv_vec[B_RX_FULL] = lv_rx_full;
  end

  irq_bank_decode #(
    .ADDR_W(ADDR_W), .OFS_STAT(OFS_STAT), .OFS_SET(OFS_SET),
    .OFS_CLR(OFS_CLR), .OFS_VIEW(OFS_VIEW)
  ) u_dec (
    .bus_wr(bus_wr), .bus_addr(bus_addr),
    .wr_stat(wr_stat), .wr_set(wr_set), .wr_clr(wr_clr), .rd_sel(rd_sel)
  );

  irq_bank_status u_stat (
    .clk(clk), .rst_n(rst_n), .wr_stat(wr_stat), .wr_bits(wr_bits),
    .ev_vec(ev_vec), .lv_vec(lv_vec), .stat(stat_q)
  );

  irq_bank_mask u_mask (
    .clk(clk), .rst_n(rst_n), .wr_set(wr_set), .wr_clr(wr_clr),
    .wr_bits(wr_bits), .mask(mask_q)
  );

  always_comb begin
    case (rd_sel)
      RD_STAT: bus_rdata = {{PAD_W{1'b0}}, stat_q};
      RD_MASK: bus_rdata = {{PAD_W{1'b0}}, mask_q};
      default: bus_rdata = '0;
    endcase
  end

  assign irq = f_pending(stat_q, mask_q);

  logic unused_upper;
  assign unused_upper = ^bus_wdata[DATA_W-1:IRQ_W];
endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFS_STAT = 'h04,
  parameter logic [ADDR_W-1:0] OFS_SET  = 'h08,
  parameter logic [ADDR_W-1:0] OFS_CLR  = 'h0C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              ev_rx_ovf,
  input logic              ev_tx_unf,
  input logic              irq,
  input logic [6:0]        stat_q,
  input logic [6:0]        mask_q
);
  logic clr0, clr6, mask_wr;
  assign clr0    = bus_wr && bus_addr == OFS_STAT && bus_wdata[0];
  assign clr6    = bus_wr && bus_addr == OFS_STAT && bus_wdata[6];
  assign mask_wr = bus_wr && (bus_addr == OFS_SET || bus_addr == OFS_CLR);

  p_hold_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[0] && !clr0) |=> stat_q[0]);
  p_hold_unf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[6] && !clr6) |=> stat_q[6]);
  p_event_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_ovf || ev_tx_unf) |=> (stat_q[0] || !$past(ev_rx_ovf)) && (stat_q[6] || !$past(ev_tx_unf)));
  p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_SET) |=>
      ((mask_q & $past(bus_wdata[6:0]) & 7'h7D) == ($past(bus_wdata[6:0]) & 7'h7D)));
  p_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_CLR) |=> ((mask_q & $past(bus_wdata[6:0])) == 7'h00));
  p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~DATA_W'(7'h7D)) == '0);
  p_no_mask_no_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 7'h00) |-> !irq);
  p_mask_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_q));
endmodule

bind irq_bank irq_bank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_STAT(OFS_STAT), .OFS_SET(OFS_SET), .OFS_CLR(OFS_CLR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .ev_rx_ovf(ev_rx_ovf), .ev_tx_unf(ev_tx_unf), .irq(irq),
  .stat_q(stat_q), .mask_q(mask_q)
);

// File: tb/sim_irq_bank.sv
module sim_irq_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ev_rx_ovf = 1'b0, ev_tx_unf = 1'b0;
  logic        lv_tx_low = 1'b0, lv_tx_full = 1'b0, lv_rx_nempty = 1'b0, lv_rx_full = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  irq_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ev_rx_ovf(ev_rx_ovf), .ev_tx_unf(ev_tx_unf),
    .lv_tx_low(lv_tx_low), .lv_tx_full(lv_tx_full), .lv_rx_nempty(lv_rx_nempty),
    .lv_rx_full(lv_rx_full), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic irq_chk(input logic exp, input string req);
    #1;
    check(req, {31'd0, irq}, {31'd0, exp});
  endtask

  task automatic pulse_ovf();
    @(negedge clk); ev_rx_ovf = 1'b1;
    @(negedge clk); ev_rx_ovf = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk(8'h04, 32'h0, "R1 status");
    rd_chk(8'h10, 32'h0, "R1 mask");
    irq_chk(1'b0, "R1 irq");
  endtask

  task automatic t_levels();
    @(negedge clk); lv_tx_low = 1'b1; #1;
    bus_addr = 8'h04; #1; check("R2 tx_low", bus_rdata, 32'h04);
    lv_tx_low = 1'b0; lv_rx_full = 1'b1; #1; check("R2 rx_full", bus_rdata, 32'h20);
    lv_tx_low = 1'b1; lv_tx_full = 1'b1; lv_rx_nempty = 1'b1; #1;
    check("R2 all levels", bus_rdata, 32'h3C);
    lv_tx_low = 1'b0; lv_tx_full = 1'b0; lv_rx_nempty = 1'b0; lv_rx_full = 1'b0; #1;
    check("R2 levels gone", bus_rdata, 32'h0);
  endtask

  task automatic t_sticky();
    pulse_ovf();
    repeat (3) @(negedge clk);
    rd_chk(8'h04, 32'h01, "R3 ovf latched");
    wr(8'h04, 32'h0);
    rd_chk(8'h04, 32'h01, "R4 zero write keeps");
    wr(8'h04, 32'h01);
    rd_chk(8'h04, 32'h0, "R3 ovf cleared");
    @(negedge clk); ev_tx_unf = 1'b1;
    @(negedge clk); ev_tx_unf = 1'b0;
    rd_chk(8'h04, 32'h40, "R3 unf latched");
    wr(8'h04, 32'h01);
    rd_chk(8'h04, 32'h40, "R4 other bit kept");
    wr(8'h04, 32'h40);
    rd_chk(8'h04, 32'h0, "R3 unf cleared");
  endtask

  task automatic t_level_noclr();
    @(negedge clk); lv_rx_nempty = 1'b1;
    wr(8'h04, 32'h10);
    rd_chk(8'h04, 32'h10, "R4 level not cleared");
    @(negedge clk); lv_rx_nempty = 1'b0;
  endtask

  task automatic t_set_wins();
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h01; ev_rx_ovf = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; ev_rx_ovf = 1'b0;
    rd_chk(8'h04, 32'h01, "R5 event beats clear");
    wr(8'h04, 32'h01);
    rd_chk(8'h04, 32'h0, "R5 cleanup");
  endtask

  task automatic t_mask();
    wr(8'h08, 32'h11);
    rd_chk(8'h10, 32'h11, "R6 set");
    wr(8'h08, 32'h04);
    rd_chk(8'h10, 32'h15, "R6 set keeps others");
    wr(8'h0C, 32'h10);
    rd_chk(8'h10, 32'h05, "R7 clear");
    rd_chk(8'h08, 32'h0, "R8 set port reads zero");
    rd_chk(8'h0C, 32'h0, "R8 clear port reads zero");
    wr(8'h0C, 32'hFFFF_FFFF);
    rd_chk(8'h10, 32'h0, "R7 clear all");
  endtask

  task automatic t_reserved();
    wr(8'h08, 32'hFFFF_FFFF);
    rd_chk(8'h10, 32'h7D, "R9 reserved mask bits");
    pulse_ovf();
    wr(8'h04, 32'hFFFF_FFBE);
    rd_chk(8'h04, 32'h01, "R9 reserved status write");
    wr(8'h04, 32'h01);
    wr(8'h0C, 32'hFFFF_FFFF);
  endtask

  task automatic t_irq();
    wr(8'h08, 32'h10);
    irq_chk(1'b0, "R10 masked but no status");
    @(negedge clk); lv_rx_nempty = 1'b1;
    irq_chk(1'b1, "R10 level raises irq");
    wr(8'h0C, 32'h10);
    irq_chk(1'b0, "R10 mask clear drops irq");
    @(negedge clk); lv_rx_nempty = 1'b0;
    pulse_ovf();
    irq_chk(1'b0, "R10 unmasked event");
    wr(8'h08, 32'h01);
    irq_chk(1'b1, "R10 sticky with mask");
    wr(8'h04, 32'h01);
    irq_chk(1'b0, "R10 irq after clear");
  endtask

  task automatic t_other();
    wr(8'h10, 32'h7D);
    rd_chk(8'h10, 32'h01, "R11 view not writable");
    wr(8'h00, 32'hFFFF_FFFF);
    rd_chk(8'h10, 32'h01, "R11 offset 0 ignored");
    pulse_ovf();
    wr(8'h14, 32'h01);
    rd_chk(8'h04, 32'h01, "R11 status untouched");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_levels();
    t_sticky();
    t_level_noclr();
    t_set_wins();
    t_mask();
    t_reserved();
    t_irq();
    t_other();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule